// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block turns a two-word interrupt command, written by a local agent, into delivery strobes for up to eight targets. The agent first writes the high word, which holds the destination, and then the low word. Writing the low word sends the command. On the send the block decodes the vector, delivery mode, destination mode, level, trigger and shorthand. It then compares the destination with every target's physical ID, logical ID and addressing format, which are kept in a small register file. One registered cycle later it raises a strobe for each receiving target. The vector, mode, level and trigger are presented alongside the strobes.

In lowest-priority mode only one target receives the interrupt. A rotation pointer is kept for each vector. The block picks the first enabled matching target found after that pointer, wrapping around. The chosen target becomes the new pointer for that vector. A logical broadcast in lowest-priority mode is refused when any target uses the clustered format. In that case the block raises an error pulse instead of delivering.

Top module: `int_dest_matcher`

## Requirements
- R1: A write of the low word (`cmd_we`=1, `cmd_hi`=0) is a send. Its strobes appear in the cycle after the write and last exactly one cycle. With no send, `dlv_strobe` is zero.
- R2: A write of the high word keeps only bits 31:24, which form the destination. `cmd_hi_q` reads back those bits with bits 23:0 as zero.
- R3: The stored low word `cmd_lo_q` equals the written value with bit 12 forced to zero. Its fields are: vector in 7:0, mode in 10:8, logical-destination flag in 11, level in 14, trigger in 15 and shorthand in 19:18.
- R4: With shorthand 0 and bit 11 clear, a target matches when its physical ID equals the destination.
- R5: With shorthand 0 and bit 11 set, a target in flat format (`cfg_cluster`=0) matches when its logical ID ANDed with the destination is nonzero.
- R6: With shorthand 0 and bit 11 set, a target in clustered format matches when its logical ID's upper nibble equals the destination's upper nibble and the lower nibbles share a set bit.
- R7: Shorthand 1 matches only the sender `cmd_src`. Shorthand 2 matches every target. Shorthand 3 matches every target except the sender.
- R8: Mode 3'b001 (lowest priority) strobes exactly one target. The block scans from the vector's pointer plus one, wraps around, and takes the first target that matches and is enabled. That target becomes the vector's pointer. Every pointer resets to 0. Other modes strobe all matching targets regardless of enable.
- R9: In lowest-priority mode with no enabled matching target, no strobe is raised and the vector's pointer is unchanged.
- R10: A send with shorthand 0, bit 11 set, mode 3'b001 and destination 0xFF, while any target is in clustered format, raises `dst_error` for one cycle instead of strobes. The pointer is unchanged.
- R11: With each strobe, `dlv_vector`, `dlv_mode`, `dlv_level` and `dlv_trigger` carry the sent word's fields.
- R12: After reset, strobes, error, both stored words and all target entries are zero.
- R13: A target configuration write in the same cycle as a send affects later sends only. The send uses the configuration held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one target's configuration |
| cfg_sel | input | 3 | Target index for the configuration write |
| cfg_phys_id | input | 8 | Physical ID |
| cfg_log_id | input | 8 | Logical ID |
| cfg_cluster | input | 1 | 1 = clustered logical format, 0 = flat |
| cfg_enable | input | 1 | Target may be picked in lowest-priority mode |
| cmd_we | input | 1 | Command word write |
| cmd_hi | input | 1 | 1 = high word, 0 = low word (send) |
| cmd_wdata | input | 32 | Command word data |
| cmd_src | input | 3 | Index of the sending target |
| cmd_lo_q | output | 32 | Stored low word |
| cmd_hi_q | output | 32 | Stored high word |
| dlv_strobe | output | 8 | One bit per receiving target |
| dlv_vector | output | 8 | Vector of the last send |
| dlv_mode | output | 3 | Delivery mode of the last send |
| dlv_level | output | 1 | Level bit of the last send |
| dlv_trigger | output | 1 | Trigger bit of the last send |
| dst_error | output | 1 | Refused broadcast in lowest-priority mode |

## Verification
A send and a target configuration write can occur in the same cycle. Both may even address the target that decides the match or the rotation pick. The bench deliberately issues sends that carry a simultaneous configuration write to a random target. It checks the strobes against a model that still holds the old configuration, and applies the new entry only afterwards. Mismatches in later sends expose any design that lets the new configuration take effect early, or lets it be lost.

// File: rtl/imd_pkg.sv
package imd_pkg;
  localparam int WORD_W   = 32;
  localparam int VEC_W    = 8;
  localparam int MODE_W   = 3;
  localparam int DEST_W   = 8;
  localparam int NUM_VEC  = 1 << VEC_W;
  localparam int PEND_BIT = 12;

  localparam logic [MODE_W-1:0] DM_LOWEST = 3'b001;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [MODE_W-1:0] mode;
    logic              logical;
    logic              level;
    logic              trigger;
    shorthand_e        shorthand;
  } cmd_t;

  function automatic cmd_t decode_lo(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.vector    = w[7:0];
    c.mode      = w[10:8];
    c.logical   = w[11];
    c.level     = w[14];
    c.trigger   = w[15];
    c.shorthand = shorthand_e'(w[19:18]);
    return c;
  endfunction
endpackage

// File: rtl/imd_tgt_file.sv
module imd_tgt_file #(
  parameter int NUM_TGT = 8,
  parameter int IDX_W   = 3,
  parameter int ID_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [IDX_W-1:0]              sel,
  input  logic [ID_W-1:0]               phys_in,
  input  logic [ID_W-1:0]               log_in,
  input  logic                          cluster_in,
  input  logic                          enable_in,
  output logic [NUM_TGT-1:0][ID_W-1:0]  phys_q,
  output logic [NUM_TGT-1:0][ID_W-1:0]  log_q,
  output logic [NUM_TGT-1:0]            cluster_q,
  output logic [NUM_TGT-1:0]            enable_q
);
  for (genvar g = 0; g < NUM_TGT; g++) begin : g_entry
    logic load;
    assign load = we && (sel == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phys_q[g]    <= '0;
        log_q[g]     <= '0;
        cluster_q[g] <= 1'b0;
        enable_q[g]  <= 1'b0;
      end else if (load) begin
        phys_q[g]    <= phys_in;
        log_q[g]     <= log_in;
        cluster_q[g] <= cluster_in;
        enable_q[g]  <= enable_in;
      end
    end
  end
endmodule

// File: rtl/imd_match.sv
module imd_match
  import imd_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int IDX_W   = 3
) (
  input  shorthand_e                      shorthand,
  input  logic                            logical,
  input  logic [MODE_W-1:0]               mode,
  input  logic [DEST_W-1:0]               dest,
  input  logic [IDX_W-1:0]                src,
  input  logic [NUM_TGT-1:0][DEST_W-1:0]  phys_q,
  input  logic [NUM_TGT-1:0][DEST_W-1:0]  log_q,
  input  logic [NUM_TGT-1:0]              cluster_q,
  output logic [NUM_TGT-1:0]              hit,
  output logic                            bcast_err
);
  localparam int NIB = DEST_W / 2;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    logic is_src;
    logic addr_hit;
    assign is_src = (src == IDX_W'(g));

    always_comb begin
      if (!logical) begin
        addr_hit = (phys_q[g] == dest);
      end else if (cluster_q[g]) begin
        addr_hit = (log_q[g][DEST_W-1:NIB] == dest[DEST_W-1:NIB]) &&
                   (|(log_q[g][NIB-1:0] & dest[NIB-1:0]));
      end else begin
        addr_hit = |(log_q[g] & dest);
      end
    end

    always_comb begin
      unique case (shorthand)
        SH_NONE:   hit[g] = addr_hit;
        SH_SELF:   hit[g] = is_src;
        SH_ALL:    hit[g] = 1'b1;
        SH_OTHERS: hit[g] = !is_src;
        default:   hit[g] = 1'b0;
      endcase
    end
  end

  assign bcast_err = (shorthand == SH_NONE) && logical && (mode == DM_LOWEST) &&
                     (&dest) && (|cluster_q);
endmodule

// File: rtl/imd_rr.sv
module imd_rr #(
  parameter int NUM_TGT = 8,
  parameter int IDX_W   = 3,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [VEC_W-1:0]   vector,
  input  logic [NUM_TGT-1:0] cand,
  output logic [NUM_TGT-1:0] pick,
  output logic               any
);
  localparam int NUM_VEC = 1 << VEC_W;

  logic [IDX_W-1:0] ptr_q [NUM_VEC];
  logic [IDX_W-1:0] cur_ptr;
  logic [IDX_W-1:0] new_ptr;

  assign cur_ptr = ptr_q[vector];

  always_comb begin
    pick    = '0;
    any     = 1'b0;
    new_ptr = cur_ptr;
    for (int k = 1; k <= NUM_TGT; k++) begin
      int j;
      j = (int'(cur_ptr) + k) % NUM_TGT;
      if (!any && cand[j]) begin
        pick[j] = 1'b1;
        any     = 1'b1;
        new_ptr = IDX_W'(j);
      end
    end
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ptr
    logic upd;
    assign upd = go && any && (vector == VEC_W'(v));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[v] <= '0;
      else if (upd) ptr_q[v] <= new_ptr;
    end
  end
endmodule

// File: rtl/int_dest_matcher.sv
module int_dest_matcher
  import imd_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int IDX_W   = $clog2(NUM_TGT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_sel,
  input  logic [DEST_W-1:0]   cfg_phys_id,
  input  logic [DEST_W-1:0]   cfg_log_id,
  input  logic                cfg_cluster,
  input  logic                cfg_enable,
  input  logic                cmd_we,
  input  logic                cmd_hi,
  input  logic [WORD_W-1:0]   cmd_wdata,
  input  logic [IDX_W-1:0]    cmd_src,
  output logic [WORD_W-1:0]   cmd_lo_q,
  output logic [WORD_W-1:0]   cmd_hi_q,
  output logic [NUM_TGT-1:0]  dlv_strobe,
  output logic [VEC_W-1:0]    dlv_vector,
  output logic [MODE_W-1:0]   dlv_mode,
  output logic                dlv_level,
  output logic                dlv_trigger,
  output logic                dst_error
);
  logic [NUM_TGT-1:0][DEST_W-1:0] phys_q, log_q;
  logic [NUM_TGT-1:0]             cluster_q, enable_q;

  logic [DEST_W-1:0] dest_q;
  logic              send, hi_wr;
  cmd_t              cmd;
  logic [NUM_TGT-1:0] hit, cand, pick, strobe_d;
  logic              bcast_err, rr_any, lowest, rr_go;
  logic [WORD_W-1:0] lo_clean;

  imd_tgt_file #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W), .ID_W(DEST_W)) u_tgt (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .phys_in(cfg_phys_id), .log_in(cfg_log_id),
    .cluster_in(cfg_cluster), .enable_in(cfg_enable),
    .phys_q(phys_q), .log_q(log_q), .cluster_q(cluster_q), .enable_q(enable_q)
  );

  assign send     = cmd_we && !cmd_hi;
  assign hi_wr    = cmd_we && cmd_hi;
  assign cmd      = decode_lo(cmd_wdata);
  assign lo_clean = cmd_wdata & ~(WORD_W'(1) << PEND_BIT);
  assign lowest   = (cmd.mode == DM_LOWEST);

  imd_match #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_match (
    .shorthand(cmd.shorthand), .logical(cmd.logical), .mode(cmd.mode),
    .dest(dest_q), .src(cmd_src),
    .phys_q(phys_q), .log_q(log_q), .cluster_q(cluster_q),
    .hit(hit), .bcast_err(bcast_err)
  );

  assign cand  = hit & enable_q;
  assign rr_go = send && lowest && !bcast_err;

  imd_rr #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .go(rr_go), .vector(cmd.vector),
    .cand(cand), .pick(pick), .any(rr_any)
  );

  always_comb begin
    strobe_d = '0;
    if (send && !bcast_err) begin
      if (lowest) strobe_d = rr_any ? pick : '0;
      else        strobe_d = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_lo_q <= '0;
    end else if (send) begin
      cmd_lo_q <= lo_clean;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
    end else if (hi_wr) begin
      dest_q <= cmd_wdata[WORD_W-1 -: DEST_W];
    end
  end

  assign cmd_hi_q = {dest_q, {(WORD_W-DEST_W){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_strobe <= '0;
      dst_error  <= 1'b0;
    end else begin
      dlv_strobe <= strobe_d;
      dst_error  <= send && bcast_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_vector  <= '0;
      dlv_mode    <= '0;
      dlv_level   <= 1'b0;
      dlv_trigger <= 1'b0;
    end else if (send) begin
      dlv_vector  <= cmd.vector;
      dlv_mode    <= cmd.mode;
      dlv_level   <= cmd.level;
      dlv_trigger <= cmd.trigger;
    end
  end
endmodule

// File: rtl/imd_checker.sv
module imd_checker #(
  parameter int NUM_TGT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_we,
  input logic               cmd_hi,
  input logic [31:0]        cmd_wdata,
  input logic [31:0]        cmd_lo_q,
  input logic [31:0]        cmd_hi_q,
  input logic [NUM_TGT-1:0] dlv_strobe,
  input logic [2:0]         dlv_mode,
  input logic               dst_error
);
  a_r1_strobe_after_send: assert property (@(posedge clk) disable iff (!rst_n)
    (|dlv_strobe) |-> $past(cmd_we && !cmd_hi));

  a_r2_hi_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_we && cmd_hi) |-> (cmd_hi_q == {$past(cmd_wdata[31:24]), 24'h0}));

  a_r3_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_we && !cmd_hi) |-> (cmd_lo_q == ($past(cmd_wdata) & 32'hFFFF_EFFF)));

  a_r8_lowest_single: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_mode == 3'b001) |-> $onehot0(dlv_strobe));

  a_r10_error_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dst_error |-> (dlv_strobe == '0));

  a_r10_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dst_error |=> !dst_error || $past(cmd_we && !cmd_hi));
endmodule

bind int_dest_matcher imd_checker #(.NUM_TGT(NUM_TGT)) u_imd_checker (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_hi(cmd_hi),
  .cmd_wdata(cmd_wdata), .cmd_lo_q(cmd_lo_q), .cmd_hi_q(cmd_hi_q),
  .dlv_strobe(dlv_strobe), .dlv_mode(dlv_mode), .dst_error(dst_error)
);

// File: tb/int_dest_matcher_test.sv
`timescale 1ns/1ps
module int_dest_matcher_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_phys_id = '0, cfg_log_id = '0;
  logic        cfg_cluster = 1'b0, cfg_enable = 1'b0;
  logic        cmd_we = 1'b0, cmd_hi = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [2:0]  cmd_src = '0;
  logic [31:0] cmd_lo_q, cmd_hi_q;
  logic [N-1:0] dlv_strobe;
  logic [7:0]  dlv_vector;
  logic [2:0]  dlv_mode;
  logic        dlv_level, dlv_trigger, dst_error;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_id [N];
  logic [7:0] m_log [N];
  bit         m_clu [N];
  bit         m_en [N];
  logic [2:0] m_ptr [256];
  logic [7:0] m_dest;

  always #2.5 clk = ~clk;

  int_dest_matcher uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_phys_id(cfg_phys_id), .cfg_log_id(cfg_log_id),
    .cfg_cluster(cfg_cluster), .cfg_enable(cfg_enable),
    .cmd_we(cmd_we), .cmd_hi(cmd_hi), .cmd_wdata(cmd_wdata), .cmd_src(cmd_src),
    .cmd_lo_q(cmd_lo_q), .cmd_hi_q(cmd_hi_q), .dlv_strobe(dlv_strobe),
    .dlv_vector(dlv_vector), .dlv_mode(dlv_mode), .dlv_level(dlv_level),
    .dlv_trigger(dlv_trigger), .dst_error(dst_error)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit addr_match(input int t, input logic [31:0] lo, input logic [2:0] src);
    logic [1:0] sh;
    sh = lo[19:18];
    case (sh)
      2'd1: return t == int'(src);
      2'd2: return 1'b1;
      2'd3: return t != int'(src);
      default: begin
        if (!lo[11]) return m_id[t] == m_dest;
        if (m_clu[t]) return (m_log[t][7:4] == m_dest[7:4]) && (|(m_log[t][3:0] & m_dest[3:0]));
        return |(m_log[t] & m_dest);
      end
    endcase
  endfunction

  task automatic predict(input logic [31:0] lo, input logic [2:0] src,
                         output logic [N-1:0] strb, output bit err);
    logic [N-1:0] hit;
    bit anyclu;
    anyclu = 0;
    for (int t = 0; t < N; t++) begin
      hit[t] = addr_match(t, lo, src);
      anyclu |= m_clu[t];
    end
    err  = (lo[19:18] == 2'd0) && lo[11] && (lo[10:8] == 3'b001) && (m_dest == 8'hFF) && anyclu;
    strb = '0;
    if (!err) begin
      if (lo[10:8] == 3'b001) begin
        for (int k = 1; k <= N; k++) begin
          int j;
          j = (int'(m_ptr[lo[7:0]]) + k) % N;
          if (strb == '0 && hit[j] && m_en[j]) strb[j] = 1'b1;
        end
        for (int j = 0; j < N; j++) if (strb[j]) m_ptr[lo[7:0]] = 3'(j);
      end else begin
        strb = hit;
      end
    end
  endtask

  task automatic cfg(input int idx, input logic [7:0] id, input logic [7:0] lg,
                     input bit clu, input bit en);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(idx); cfg_phys_id = id; cfg_log_id = lg;
    cfg_cluster = clu; cfg_enable = en;
    @(negedge clk);
    cfg_we = 0;
    m_id[idx] = id; m_log[idx] = lg; m_clu[idx] = clu; m_en[idx] = en;
  endtask

  task automatic wr_hi(input logic [31:0] d);
    @(negedge clk);
    cmd_we = 1; cmd_hi = 1; cmd_wdata = d;
    @(negedge clk);
    cmd_we = 0; cmd_hi = 0;
    m_dest = d[31:24];
    chk(cmd_hi_q == {d[31:24], 24'h0}, "R2", "high word", cmd_hi_q, {d[31:24], 24'h0});
  endtask

  // send a low word; optionally a config write in the same cycle (R13)
  task automatic send(input logic [31:0] lo, input logic [2:0] src, input string req,
                      input bit with_cfg = 0, input int ci = 0, input logic [7:0] cid = 0,
                      input logic [7:0] clg = 0, input bit cclu = 0, input bit cen = 0);
    logic [N-1:0] es;
    bit ee;
    predict(lo, src, es, ee);
    @(negedge clk);
    cmd_we = 1; cmd_hi = 0; cmd_wdata = lo; cmd_src = src;
    if (with_cfg) begin
      cfg_we = 1; cfg_sel = 3'(ci); cfg_phys_id = cid; cfg_log_id = clg;
      cfg_cluster = cclu; cfg_enable = cen;
    end
    @(negedge clk);
    cmd_we = 0; cfg_we = 0;
    if (with_cfg) begin
      m_id[ci] = cid; m_log[ci] = clg; m_clu[ci] = cclu; m_en[ci] = cen;
    end
    chk(dlv_strobe == es, req, "strobes", 32'(dlv_strobe), 32'(es));
    chk(dst_error == ee, "R10", "error flag", 32'(dst_error), 32'(ee));
    chk(cmd_lo_q == (lo & 32'hFFFF_EFFF), "R3", "stored low word", cmd_lo_q, lo & 32'hFFFF_EFFF);
    if (es != '0)
      chk({dlv_vector, dlv_mode, dlv_level, dlv_trigger} == {lo[7:0], lo[10:8], lo[14], lo[15]},
          "R11", "fields", 32'({dlv_vector, dlv_mode, dlv_level, dlv_trigger}),
          32'({lo[7:0], lo[10:8], lo[14], lo[15]}));
  endtask

  function automatic logic [31:0] mk(input logic [7:0] vec, input logic [2:0] mode,
                                     input bit logical, input logic [1:0] sh,
                                     input bit lvl, input bit trg);
    return {12'h0, sh, 2'b00, trg, lvl, 1'b0, 1'b1, logical, mode, vec};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int v = 0; v < 256; v++) m_ptr[v] = '0;
    for (int t = 0; t < N; t++) begin
      m_id[t] = 0; m_log[t] = 0; m_clu[t] = 0; m_en[t] = 0;
    end
    m_dest = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(dlv_strobe == 0, "R12", "reset strobes", 32'(dlv_strobe), 0);
    chk(dst_error == 0, "R12", "reset error", 32'(dst_error), 0);
    chk(cmd_lo_q == 0, "R12", "reset low word", cmd_lo_q, 0);
    chk(cmd_hi_q == 0, "R12", "reset high word", cmd_hi_q, 0);
    send(mk(8'h30, 3'b000, 0, 2'd0, 0, 0), 3'd0, "R12");

    wr_hi(32'h1234_5678);                      // R2
    for (int t = 0; t < N; t++) cfg(t, 8'(t), 8'(1 << t), 0, 1);

    wr_hi(32'h05FF_FFFF);
    send(mk(8'h41, 3'b000, 0, 2'd0, 1, 1), 3'd0, "R4");
    // R1: strobe lasts one cycle only
    @(negedge clk);
    chk(dlv_strobe == 0, "R1", "strobe pulse width", 32'(dlv_strobe), 0);
    wr_hi(32'h0A00_0000);
    send(mk(8'h42, 3'b000, 1, 2'd0, 0, 1), 3'd0, "R5");
    send(mk(8'h43, 3'b000, 0, 2'd1, 1, 0), 3'd2, "R7");
    send(mk(8'h44, 3'b000, 0, 2'd2, 0, 0), 3'd2, "R7");
    send(mk(8'h45, 3'b000, 0, 2'd3, 0, 0), 3'd0, "R7");

    for (int i = 0; i < 10; i++) send(mk(8'h50, 3'b001, 0, 2'd2, 0, 0), 3'd0, "R8");
    send(mk(8'h51, 3'b001, 0, 2'd2, 0, 0), 3'd0, "R8");
    wr_hi(32'h7700_0000);
    send(mk(8'h51, 3'b001, 0, 2'd0, 0, 0), 3'd0, "R9");
    send(mk(8'h51, 3'b001, 0, 2'd2, 0, 0), 3'd0, "R9");

    cfg(4, 8'h04, 8'h23, 1, 1);
    cfg(5, 8'h05, 8'h31, 1, 1);
    wr_hi(32'h2100_0000);
    send(mk(8'h60, 3'b000, 1, 2'd0, 0, 0), 3'd0, "R6");
    wr_hi(32'h3200_0000);
    send(mk(8'h61, 3'b000, 1, 2'd0, 0, 0), 3'd0, "R6");

    wr_hi(32'hFF00_0000);
    send(mk(8'h62, 3'b001, 1, 2'd0, 0, 0), 3'd0, "R10");
    send(mk(8'h62, 3'b001, 0, 2'd2, 0, 0), 3'd0, "R10");

    wr_hi(32'h0300_0000);
    send(mk(8'h70, 3'b000, 0, 2'd0, 0, 0), 3'd0, "R13", 1, 3, 8'h09, 8'h00, 0, 1);
    send(mk(8'h70, 3'b000, 0, 2'd0, 0, 0), 3'd0, "R13");

    for (int i = 0; i < 400; i++) begin
      int r;
      logic [2:0] md;
      r = $urandom_range(0, 9);
      if (r == 0) cfg($urandom_range(0, N-1), 8'($urandom_range(0, 9)), 8'($urandom),
                      $urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0);
      if (r == 1) wr_hi(($urandom_range(0, 4) == 0) ? 32'hFF00_0000 : {8'($urandom_range(0, 255)), 24'($urandom)});
      case ($urandom_range(0, 3))
        0: md = 3'b000;
        1, 2: md = 3'b001;
        default: md = 3'($urandom);
      endcase
      send({12'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), md, 8'($urandom_range(0, 7))},
           3'($urandom), "R8", $urandom_range(0, 5) == 0, $urandom_range(0, N-1),
           8'($urandom_range(0, 9)), 8'($urandom), $urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule